// File: doc/BRIEF.md
# Serial PCM Audio Receiver

This block turns a three-wire serial audio stream (bit clock, word clock, data) into parallel stereo samples. It runs entirely in the bit-clock domain: every rising edge of the bit clock samples the data line and the word clock. Each word-clock period yields one left and one right sample. Both are presented together with a single-cycle valid strobe.

Two framings are supported. The first is right-justified MSB-first, where the sample's LSB is the final bit before the word clock changes. The second is I2S, where the MSB follows the word-clock change by one bit clock. Samples may be 16 or 18 bits. The word-clock level that marks the left channel can be inverted in right-justified mode. Outputs are 18-bit two's-complement values. A 16-bit sample is placed in the upper 16 bits with two zero LSBs, which keeps its sign.

Top module: `pcm_serial_rx`

## Requirements
- R1: While `rst_n` is low, `left_out` and `right_out` are zero and `pair_valid` is low. These values hold after reset until the first stereo pair is complete.
- R2: In right-justified mode (`frame_i2s`=0), the sample is formed from the last N data bits sampled on rising bit-clock edges before the word clock changes, MSB first. Bits sent earlier in the same word-clock half period do not affect the sample.
- R3: In right-justified mode with `wclk_invert`=0, a word sent while `wclk` is high is the left sample and a word sent while it is low is the right sample.
- R4: In right-justified mode with `wclk_invert`=1, the channel levels are swapped: `wclk` low carries left and high carries right.
- R5: In I2S mode (`frame_i2s`=1), `wclk` low carries left and high carries right, whatever the value of `wclk_invert`. The MSB is the bit sampled on the second rising edge after the word clock changes. Bits beyond the N-th, and the bit sampled on the first edge, are ignored.
- R6: `word18`=0 selects N=16 and `word18`=1 selects N=18. A 16-bit sample appears as output bits [17:2], with bits [1:0] zero.
- R7: `pair_valid` pulses high for exactly one bit-clock cycle per stereo pair, after the right sample is complete. `left_out` and `right_out` change only on the cycle in which `pair_valid` is high.
- R8: In right-justified mode, `pair_valid` and the new right sample appear after the rising edge that first samples the word clock at its new level once the right half has ended. That edge is the one that captures the first bit of the next left half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all sampling on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wclk | input | 1 | Word clock marking the channel halves |
| sdata | input | 1 | Serial sample data |
| frame_i2s | input | 1 | 0 = right-justified, 1 = I2S framing |
| word18 | input | 1 | 0 = 16-bit words, 1 = 18-bit words |
| wclk_invert | input | 1 | Swap the left level in right-justified mode |
| left_out | output | 18 | Left sample of the latest pair |
| right_out | output | 18 | Right sample of the latest pair |
| pair_valid | output | 1 | One-cycle strobe: a new pair is on the outputs |

## Verification
The assertions watch on every cycle that the valid strobe is never wider than one cycle and that it only follows a completed right word. They also check that the outputs do not move between strobes, that a detected word-clock change really flips the registered level, and that the I2S bit counter stays within its range. Only the bench scenarios can show that the samples hold the right bits. This covers the bit alignment of each framing, the channel assignment under each polarity setting, the 16-bit left alignment, the disregard of padding bits, and the exact cycle on which a pair appears.

// File: rtl/pcm_rx_pkg.sv
// Shared constants and types for the serial PCM receiver.
package pcm_rx_pkg;
    localparam int PCM_MAX_W = 18;   // widest supported sample
    localparam int PCM_MIN_W = 16;   // narrow sample width

    typedef enum logic {
        FRAME_RJ  = 1'b0,
        FRAME_I2S = 1'b1
    } frame_t;
endpackage

// File: rtl/pcm_wclk_track.sv
// Word-clock tracker: registers the word clock and flags the cycle in which
// a level change is first sampled. It also reports whether the previous and
// the current sampled levels denote the left channel.
// Assumes the word clock is synchronous to the bit clock.
module pcm_wclk_track
    import pcm_rx_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wclk,
    input  frame_t frame,
    input  logic   invert,
    output logic   wc_flip,
    output logic   left_prev,
    output logic   left_now
);
    logic wclk_q;
    logic primed;
    logic left_level;

    // Level that marks the left channel; polarity swap applies to RJ only.
    assign left_level = (frame == FRAME_I2S) ? 1'b0 : ~invert;

    // Remember last sampled word-clock level; primed blocks a false flip after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wclk_q <= 1'b0;
            primed <= 1'b0;
        end else begin
            wclk_q <= wclk;
            primed <= 1'b1;
        end
    end

    assign wc_flip   = primed && (wclk != wclk_q);
    assign left_prev = (wclk_q == left_level);
    assign left_now  = (wclk == left_level);

    // R3 label group: a reported flip must really change the registered level.
    a_r3_flip_changes_level: assert property (@(posedge clk) disable iff (!rst_n)
        wc_flip |=> (wclk_q != $past(wclk_q)));
endmodule

// File: rtl/pcm_rj_capture.sv
// Right-justified capture: shifts every data bit in continuously. On each
// word-clock flip it emits the last N bits as the word of the half that just
// ended. Assumes a half period holds at least N bits.
module pcm_rj_capture #(
    parameter int MAX_W = pcm_rx_pkg::PCM_MAX_W,
    parameter int MIN_W = pcm_rx_pkg::PCM_MIN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sdata,
    input  logic             wide,
    input  logic             wc_flip,
    input  logic             left_prev,
    output logic             cap_stb,
    output logic             cap_left,
    output logic [MAX_W-1:0] cap_word
);
    localparam int PAD_W = MAX_W - MIN_W;

    logic [MAX_W-1:0] shreg;

    // Free-running shift register holding the most recent MAX_W bits.
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[MAX_W-2:0], sdata};
    end

    // Word of the finished half is taken before this cycle's shift.
    always_comb begin
        cap_stb  = wc_flip;
        cap_left = left_prev;
        cap_word = wide ? shreg : {shreg[MIN_W-1:0], {PAD_W{1'b0}}};
    end
endmodule

// File: rtl/pcm_i2s_capture.sv
// I2S capture: after a word-clock flip, skips one bit and then collects N
// bits MSB first. Later bits are ignored until the next flip. The counter
// rests at MAX_W when idle, so nothing is captured before the first flip.
module pcm_i2s_capture #(
    parameter int MAX_W = pcm_rx_pkg::PCM_MAX_W,
    parameter int MIN_W = pcm_rx_pkg::PCM_MIN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sdata,
    input  logic             wide,
    input  logic             wc_flip,
    input  logic             left_now,
    output logic             cap_stb,
    output logic             cap_left,
    output logic [MAX_W-1:0] cap_word
);
    localparam int PAD_W = MAX_W - MIN_W;
    localparam int CNT_W = $clog2(MAX_W + 1);
    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_W);
    localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_W);

    logic [CNT_W-1:0] bit_cnt;
    logic [CNT_W-1:0] n_bits;
    logic [MAX_W-1:0] shreg;
    logic [MAX_W-1:0] next_sh;
    logic             collecting;

    assign n_bits     = wide ? MAX_C : MIN_C;
    assign collecting = !wc_flip && (bit_cnt < n_bits);
    assign next_sh    = {shreg[MAX_W-2:0], sdata};

    // Bit counter: cleared by a flip (that bit is skipped), runs up to N.
    always_ff @(posedge clk) begin
        if (!rst_n)          bit_cnt <= MAX_C;
        else if (wc_flip)    bit_cnt <= '0;
        else if (collecting) bit_cnt <= bit_cnt + 1'b1;
    end

    // Shift register loads only while a word is being collected.
    always_ff @(posedge clk) begin
        if (!rst_n)          shreg <= '0;
        else if (collecting) shreg <= next_sh;
    end

    // Word completes on the cycle its N-th bit is sampled.
    always_comb begin
        cap_stb  = collecting && (bit_cnt == n_bits - 1'b1);
        cap_left = left_now;
        cap_word = wide ? next_sh : {next_sh[MIN_W-1:0], {PAD_W{1'b0}}};
    end

    // R5: the counter never runs past the widest word.
    a_r5_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= MAX_C);
endmodule

// File: rtl/pcm_pair_out.sv
// Pair assembler: holds the latest left word. When a right word arrives, it
// publishes both words together with a one-cycle valid strobe.
module pcm_pair_out #(
    parameter int MAX_W = pcm_rx_pkg::PCM_MAX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_stb,
    input  logic             cap_left,
    input  logic [MAX_W-1:0] cap_word,
    output logic [MAX_W-1:0] left_out,
    output logic [MAX_W-1:0] right_out,
    output logic             pair_valid
);
    logic [MAX_W-1:0] left_hold;

    // Keep the most recent left word until its right partner completes.
    always_ff @(posedge clk) begin
        if (!rst_n)                  left_hold <= '0;
        else if (cap_stb && cap_left) left_hold <= cap_word;
    end

    // Publish the pair and strobe valid for one cycle on a right word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_out   <= '0;
            right_out  <= '0;
            pair_valid <= 1'b0;
        end else if (cap_stb && !cap_left) begin
            left_out   <= left_hold;
            right_out  <= cap_word;
            pair_valid <= 1'b1;
        end else begin
            pair_valid <= 1'b0;
        end
    end

    // R7: strobe is a single-cycle pulse.
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |=> !pair_valid);

    // R7: outputs only move together with a strobe.
    a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_valid |-> ($stable(left_out) && $stable(right_out)));
endmodule

// File: rtl/pcm_serial_rx.sv
// Serial PCM receiver top: tracks the word clock, runs both framing capture
// engines and forwards the selected one into the pair assembler.
// Assumes configuration inputs are static while a stream is running.
module pcm_serial_rx
    import pcm_rx_pkg::*;
#(
    parameter int MAX_W = PCM_MAX_W,
    parameter int MIN_W = PCM_MIN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wclk,
    input  logic             sdata,
    input  logic             frame_i2s,
    input  logic             word18,
    input  logic             wclk_invert,
    output logic [MAX_W-1:0] left_out,
    output logic [MAX_W-1:0] right_out,
    output logic             pair_valid
);
    frame_t           frame;
    logic             wc_flip, left_prev, left_now;
    logic             rj_stb, rj_left, i2s_stb, i2s_left;
    logic [MAX_W-1:0] rj_word, i2s_word;
    logic             cap_stb, cap_left;
    logic [MAX_W-1:0] cap_word;

    assign frame = frame_t'(frame_i2s);

    pcm_wclk_track u_track (
        .clk(clk), .rst_n(rst_n), .wclk(wclk), .frame(frame),
        .invert(wclk_invert), .wc_flip(wc_flip),
        .left_prev(left_prev), .left_now(left_now)
    );

    pcm_rj_capture #(.MAX_W(MAX_W), .MIN_W(MIN_W)) u_rj (
        .clk(clk), .rst_n(rst_n), .sdata(sdata), .wide(word18),
        .wc_flip(wc_flip), .left_prev(left_prev),
        .cap_stb(rj_stb), .cap_left(rj_left), .cap_word(rj_word)
    );

    pcm_i2s_capture #(.MAX_W(MAX_W), .MIN_W(MIN_W)) u_i2s (
        .clk(clk), .rst_n(rst_n), .sdata(sdata), .wide(word18),
        .wc_flip(wc_flip), .left_now(left_now),
        .cap_stb(i2s_stb), .cap_left(i2s_left), .cap_word(i2s_word)
    );

    // Select the capture engine for the configured framing.
    always_comb begin
        if (frame == FRAME_I2S) begin
            cap_stb  = i2s_stb;
            cap_left = i2s_left;
            cap_word = i2s_word;
        end else begin
            cap_stb  = rj_stb;
            cap_left = rj_left;
            cap_word = rj_word;
        end
    end

    pcm_pair_out #(.MAX_W(MAX_W)) u_pair (
        .clk(clk), .rst_n(rst_n), .cap_stb(cap_stb), .cap_left(cap_left),
        .cap_word(cap_word), .left_out(left_out), .right_out(right_out),
        .pair_valid(pair_valid)
    );

    // R8: a strobe is always preceded by a completed right word.
    a_r8_valid_after_right: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |-> $past(cap_stb && !cap_left));
endmodule

// File: tb/tb_pcm_serial_rx.sv
// Directed bench for the serial PCM receiver.
module tb_pcm_serial_rx;
    localparam int HALF = 32;   // bit clocks per channel half

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wclk = 1'b0;
    logic        sdata = 1'b0;
    logic        frame_i2s = 1'b0;
    logic        word18 = 1'b0;
    logic        wclk_invert = 1'b0;
    logic [17:0] left_out, right_out;
    logic        pair_valid;

    int n_checks = 0;
    int n_bad = 0;
    int n_pairs = 0;
    logic [17:0] got_l [0:7];
    logic [17:0] got_r [0:7];

    always #2 clk = ~clk;   // 250 MHz

    pcm_serial_rx dut (
        .clk(clk), .rst_n(rst_n), .wclk(wclk), .sdata(sdata),
        .frame_i2s(frame_i2s), .word18(word18), .wclk_invert(wclk_invert),
        .left_out(left_out), .right_out(right_out), .pair_valid(pair_valid)
    );

    // Record every published pair, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && pair_valid && n_pairs < 8) begin
            got_l[n_pairs] = left_out;
            got_r[n_pairs] = right_out;
            n_pairs++;
        end
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic left_lvl();
        return frame_i2s ? 1'b0 : ~wclk_invert;
    endfunction

    function automatic logic [17:0] expect18(input logic [17:0] w);
        return word18 ? w : {w[15:0], 2'b00};
    endfunction

    task automatic do_reset(input logic i2s, input logic w18, input logic inv);
        frame_i2s = i2s; word18 = w18; wclk_invert = inv;
        @(negedge clk);
        rst_n = 1'b0; sdata = 1'b0;
        wclk = i2s ? ~left_lvl() : left_lvl();   // idle level avoids a spurious pair
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        n_pairs = 0;
    endtask

    // One channel half; padding bits are ones and must be ignored.
    task automatic send_half(input logic lvl, input logic [17:0] w);
        int n;
        n = word18 ? 18 : 16;
        for (int j = 0; j < HALF; j++) begin
            @(negedge clk);
            wclk = lvl;
            if (frame_i2s) sdata = (j >= 1 && j <= n) ? w[n-j] : 1'b1;
            else           sdata = (j >= HALF-n) ? w[n-1-(j-HALF+n)] : 1'b1;
        end
    endtask

    task automatic send_frame(input logic [17:0] l, input logic [17:0] r);
        send_half(left_lvl(), l);
        send_half(~left_lvl(), r);
    endtask

    task automatic flush();
        for (int j = 0; j < 4; j++) begin
            @(negedge clk);
            wclk = left_lvl(); sdata = 1'b0;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic run_case(input string req, input logic i2s, input logic w18,
                            input logic inv, input logic [17:0] l0, input logic [17:0] r0,
                            input logic [17:0] l1, input logic [17:0] r1);
        do_reset(i2s, w18, inv);
        send_frame(l0, r0);
        send_frame(l1, r1);
        flush();
        chk({req, " pair count"}, n_pairs, 2);
        chk({req, " left0"},  got_l[0], expect18(l0));
        chk({req, " right0"}, got_r[0], expect18(r0));
        chk({req, " left1"},  got_l[1], expect18(l1));
        chk({req, " right1"}, got_r[1], expect18(r1));
    endtask

    task automatic test_reset();
        do_reset(1'b0, 1'b0, 1'b0);
        chk("R1 left reset", left_out, 0);
        chk("R1 right reset", right_out, 0);
        chk("R1 valid reset", pair_valid, 0);
    endtask

    // R8 / R7: exact strobe cycle and single-cycle width in RJ mode.
    task automatic test_timing();
        do_reset(1'b0, 1'b1, 1'b0);
        send_frame(18'h2A5A5, 18'h15A5A);
        @(negedge clk);
        wclk = left_lvl(); sdata = 1'b0;
        @(negedge clk);
        chk("R8 valid after flip edge", pair_valid, 1);
        chk("R8 right on strobe", right_out, 18'h15A5A);
        @(negedge clk);
        chk("R7 strobe one cycle", pair_valid, 0);
        send_half(left_lvl(), 18'h3FFFF);
        chk("R7 outputs held", right_out, 18'h15A5A);
        chk("R7 no extra strobe", n_pairs, 1);
    endtask

    initial begin
        test_reset();
        run_case("R2 R3 R6 rj16",      1'b0, 1'b0, 1'b0, 18'h08001, 18'h0F00F, 18'h0FFFF, 18'h00000);
        run_case("R2 R6 rj18",         1'b0, 1'b1, 1'b0, 18'h20001, 18'h1FFFE, 18'h3FFFF, 18'h00003);
        run_case("R4 rj16 inverted",   1'b0, 1'b0, 1'b1, 18'h01234, 18'h0ABCD, 18'h08000, 18'h07FFF);
        run_case("R5 R6 i2s16",        1'b1, 1'b0, 1'b0, 18'h0C003, 18'h03FF0, 18'h00001, 18'h0FFFE);
        run_case("R5 i2s18 invert ign", 1'b1, 1'b1, 1'b1, 18'h2ABCD, 18'h15432, 18'h20000, 18'h00001);
        test_timing();
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        #800000;
        n_checks++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule